// File: doc/BRIEF.md
# DDS Programming Word Loader

This block sits between a host and the control registers of a direct digital synthesizer. The host assembles a 40-bit control frame in a staging register, then copies it into the active registers with an update strobe. In parallel mode each rising edge of a word clock puts one byte from an 8-bit bus into the byte slot chosen by an internal pointer. In serial mode each rising edge shifts one data bit into the frame. The active registers are a 32-bit tuning word, a 5-bit phase offset, a power-down flag and a clock-multiplier enable.

The frame is split into a control byte (bits 39:32) and a tuning word (bits 31:0). Control byte bit 0 (frame bit 32) is the multiplier enable. Bit 1 (frame bit 33) is the mode bit, and a frame is only committed when it is 0. Bit 2 (frame bit 34) is power-down. Bits 7:3 (frame bits 39:35) are the phase offset. A control byte whose low three bits are 011, committed in parallel mode, switches the loader to serial mode. Reset only returns to parallel mode. Reset clears the active registers and the pointer but keeps the staging frame. The host clock inputs are treated as level signals that are synchronous to `clk`. A rising edge is acted on at the same `clk` edge where the high level is first seen.

Top module: `dds_prog_loader`

## Requirements
- R1: While reset is asserted (rst_n low) and after it is released: parallel mode (serial_mode_o=0), word_ptr_o=0, tune_o=0, phase_o=0, pdown_o=0, mult_en_o=0.
- R2: In parallel mode the bytes of successive word-clock edges after an update fill slot 0 (frame bits 39:32), then slots 1..4 (31:24, 23:16, 15:8, 7:0). A committed frame drives tune_o=frame[31:0], phase_o=frame[39:35], pdown_o=frame[34] and mult_en_o=frame[32].
- R3: word_ptr_o rises by exactly one for each rising edge of wclk_i in parallel mode. Holding wclk_i high for several cycles counts as one edge.
- R4: word_ptr_o saturates at 5. Further bytes are ignored until the next update, and the frame keeps the first five bytes.
- R5: Every rising edge of upd_i returns word_ptr_o to 0.
- R6: The active outputs change only at a rising edge of upd_i. Word-clock activity alone leaves them unchanged.
- R7: In parallel mode, a frame with control bits 2:0 = 011 committed by upd_i sets serial_mode_o to 1. The active registers keep their values. Serial mode is kept until reset.
- R8: In parallel mode, a frame with bit 33 set and any other pattern in control bits 2:0 (for example 111) is ignored. The mode and the active registers are unchanged.
- R9: In serial mode each wclk_i rising edge shifts sdata_i into the frame least significant bit first. After 40 edges the first bit is at frame bit 0. A following update with bit 33 clear commits the frame as in R2.
- R10: In serial mode an update whose frame has bit 33 set leaves all active registers unchanged.
- R11: Reset does not clear the staging frame. An update after reset with no new writes commits the frame loaded before reset. Reset also returns a serial-mode loader to parallel mode.
- R12: A committed control byte with bits 2:1 = 10 sets pdown_o. One with bits 2:1 = 00 clears it.
- R13: When wclk_i and upd_i rise in the same cycle, the word-clock edge is dropped. The commit uses the frame as it was before that cycle, and word_ptr_o becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wclk_i | input | 1 | Word clock level, sampled on clk |
| upd_i | input | 1 | Update strobe level, sampled on clk |
| data_i | input | 8 | Parallel byte bus |
| sdata_i | input | 1 | Serial data bit |
| tune_o | output | 32 | Active tuning word |
| phase_o | output | 5 | Active phase offset |
| pdown_o | output | 1 | Active power-down flag |
| mult_en_o | output | 1 | Active clock-multiplier enable |
| serial_mode_o | output | 1 | 1 when the loader is in serial mode |
| word_ptr_o | output | 3 | Next byte slot for parallel writes (5 = full) |

## Verification
A wrong staging frame cannot be seen until the next update strobe. One cycle after that strobe, every byte that went to the wrong slot or shifted in the wrong order shows up as a wrong field of the tuning word, phase, power-down or multiplier outputs. A wrong pointer shows on word_ptr_o in the cycle after the word-clock edge that moved it. A mode error shows one cycle after the update that should or should not have entered serial mode, and it then spoils every later load. State that survives reset is observed by committing after reset without any new writes.

// File: rtl/dds_ldr_pkg.sv
package dds_ldr_pkg;

   typedef enum logic {
      LDR_PARALLEL = 1'b0,
      LDR_SERIAL   = 1'b1
   } ldr_mode_e;

   // bit positions inside the control byte
   localparam int CB_MULT     = 0;
   localparam int CB_MODE     = 1;
   localparam int CB_PDN      = 2;
   localparam int CB_PHASE_LO = 3;

   // low control bits that request the switch to serial loading
   localparam logic [2:0] SER_ENTRY_CODE = 3'b011;

endpackage

// File: rtl/dds_ldr_edge.sv
module dds_ldr_edge #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl_i,
   output logic [N-1:0] rise_o
);

   logic [N-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
      end else begin
         prev_q <= lvl_i;
      end
   end

   assign rise_o = lvl_i & ~prev_q;

endmodule

// File: rtl/dds_ldr_wptr.sv
module dds_ldr_wptr #(
   parameter int NWORDS = 5,
   parameter int PW     = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          word_rise_i,
   input  logic          upd_rise_i,
   input  logic          par_mode_i,
   output logic [PW-1:0] ptr_o,
   output logic          byte_we_o
);

   localparam logic [PW-1:0] FULL = PW'(NWORDS);

   logic [PW-1:0] ptr_q;
   logic          room;

   assign room      = (ptr_q != FULL);
   assign byte_we_o = word_rise_i & par_mode_i & ~upd_rise_i & room;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (upd_rise_i) begin
         ptr_q <= '0;
      end else if (byte_we_o) begin
         ptr_q <= ptr_q + 1'b1;
      end
   end

   assign ptr_o = ptr_q;

endmodule

// File: rtl/dds_ldr_frame.sv
module dds_ldr_frame #(
   parameter int BUS_W     = 8,
   parameter int FRAME_W   = 40,
   parameter int NWORDS    = 5,
   parameter int PW        = 3,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic               clk,
   input  logic               byte_we_i,
   input  logic [PW-1:0]      byte_idx_i,
   input  logic [BUS_W-1:0]   byte_i,
   input  logic               bit_we_i,
   input  logic               bit_i,
   output logic [FRAME_W-1:0] frame_o
);

   logic [FRAME_W-1:0] frame_q;
   logic [FRAME_W-1:0] frame_d;
   logic [FRAME_W-1:0] shifted;

   generate
      if (LSB_FIRST) begin : g_lsb_first
         assign shifted = {bit_i, frame_q[FRAME_W-1:1]};
      end else begin : g_msb_first
         assign shifted = {frame_q[FRAME_W-2:0], bit_i};
      end
   endgenerate

   always_comb begin
      frame_d = frame_q;
      if (bit_we_i) begin
         frame_d = shifted;
      end else if (byte_we_i) begin
         for (int i = 0; i < NWORDS; i++) begin
            if (byte_idx_i == PW'(i)) begin
               frame_d[FRAME_W-1-i*BUS_W -: BUS_W] = byte_i;
            end
         end
      end
   end

   // the staging frame deliberately has no reset
   always_ff @(posedge clk) begin
      frame_q <= frame_d;
   end

   assign frame_o = frame_q;

endmodule

// File: rtl/dds_ldr_commit.sv
module dds_ldr_commit
   import dds_ldr_pkg::*;
#(
   parameter int BUS_W  = 8,
   parameter int TUNE_W = 32,
   parameter int PH_W   = BUS_W - CB_PHASE_LO
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      upd_rise_i,
   input  logic [TUNE_W+BUS_W-1:0]   frame_i,
   output ldr_mode_e                 mode_o,
   output logic [TUNE_W-1:0]         tune_o,
   output logic [PH_W-1:0]           phase_o,
   output logic                      pdn_o,
   output logic                      mult_o
);

   logic [BUS_W-1:0] ctrl;
   logic             frame_ok;
   logic             entry_req;

   ldr_mode_e         mode_q;
   logic [TUNE_W-1:0] tune_q;
   logic [PH_W-1:0]   phase_q;
   logic              pdn_q;
   logic              mult_q;

   assign ctrl      = frame_i[TUNE_W+BUS_W-1:TUNE_W];
   assign frame_ok  = ~ctrl[CB_MODE];
   assign entry_req = (mode_q == LDR_PARALLEL) && (ctrl[2:0] == SER_ENTRY_CODE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= LDR_PARALLEL;
         tune_q  <= '0;
         phase_q <= '0;
         pdn_q   <= 1'b0;
         mult_q  <= 1'b0;
      end else if (upd_rise_i) begin
         if (frame_ok) begin
            tune_q  <= frame_i[TUNE_W-1:0];
            phase_q <= ctrl[BUS_W-1:CB_PHASE_LO];
            pdn_q   <= ctrl[CB_PDN];
            mult_q  <= ctrl[CB_MULT];
         end else if (entry_req) begin
            mode_q <= LDR_SERIAL;
         end
      end
   end

   assign mode_o  = mode_q;
   assign tune_o  = tune_q;
   assign phase_o = phase_q;
   assign pdn_o   = pdn_q;
   assign mult_o  = mult_q;

endmodule

// File: rtl/dds_prog_loader.sv
module dds_prog_loader
   import dds_ldr_pkg::*;
#(
   parameter int BUS_W     = 8,
   parameter int TUNE_W    = 32,
   parameter bit LSB_FIRST = 1'b1,
   localparam int FRAME_W  = TUNE_W + BUS_W,
   localparam int NWORDS   = FRAME_W / BUS_W,
   localparam int PW       = $clog2(NWORDS + 1),
   localparam int PH_W     = BUS_W - CB_PHASE_LO
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wclk_i,
   input  logic              upd_i,
   input  logic [BUS_W-1:0]  data_i,
   input  logic              sdata_i,
   output logic [TUNE_W-1:0] tune_o,
   output logic [PH_W-1:0]   phase_o,
   output logic              pdown_o,
   output logic              mult_en_o,
   output logic              serial_mode_o,
   output logic [PW-1:0]     word_ptr_o
);

   generate
      if ((TUNE_W % BUS_W) != 0) begin : g_bad_tune
         $error("TUNE_W must be a multiple of BUS_W");
      end
      if (BUS_W < CB_PHASE_LO + 1) begin : g_bad_bus
         $error("BUS_W too narrow for the control fields");
      end
   endgenerate

   logic [1:0]         rise;
   logic               upd_rise;
   logic               word_rise;
   logic               byte_we;
   logic               bit_we;
   logic [PW-1:0]      ptr;
   logic [FRAME_W-1:0] frame_q;
   ldr_mode_e          mode;

   dds_ldr_edge #(.N(2)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  ({upd_i, wclk_i}),
      .rise_o (rise)
   );

   assign word_rise = rise[0];
   assign upd_rise  = rise[1];
   assign bit_we    = word_rise & (mode == LDR_SERIAL) & ~upd_rise;

   dds_ldr_wptr #(.NWORDS(NWORDS), .PW(PW)) u_wptr (
      .clk         (clk),
      .rst_n       (rst_n),
      .word_rise_i (word_rise),
      .upd_rise_i  (upd_rise),
      .par_mode_i  (mode == LDR_PARALLEL),
      .ptr_o       (ptr),
      .byte_we_o   (byte_we)
   );

   dds_ldr_frame #(
      .BUS_W     (BUS_W),
      .FRAME_W   (FRAME_W),
      .NWORDS    (NWORDS),
      .PW        (PW),
      .LSB_FIRST (LSB_FIRST)
   ) u_frame (
      .clk        (clk),
      .byte_we_i  (byte_we),
      .byte_idx_i (ptr),
      .byte_i     (data_i),
      .bit_we_i   (bit_we),
      .bit_i      (sdata_i),
      .frame_o    (frame_q)
   );

   dds_ldr_commit #(.BUS_W(BUS_W), .TUNE_W(TUNE_W), .PH_W(PH_W)) u_commit (
      .clk        (clk),
      .rst_n      (rst_n),
      .upd_rise_i (upd_rise),
      .frame_i    (frame_q),
      .mode_o     (mode),
      .tune_o     (tune_o),
      .phase_o    (phase_o),
      .pdn_o      (pdown_o),
      .mult_o     (mult_en_o)
   );

   assign serial_mode_o = (mode == LDR_SERIAL);
   assign word_ptr_o    = ptr;

endmodule

// File: rtl/dds_prog_loader_chk.sv
module dds_prog_loader_chk #(
   parameter int NWORDS  = 5,
   parameter int PW      = 3,
   parameter int TUNE_W  = 32,
   parameter int PH_W    = 5,
   parameter int FRAME_W = 40
) (
   input logic               clk,
   input logic               rst_n,
   input logic               upd_i,
   input logic [PW-1:0]      word_ptr_o,
   input logic [TUNE_W-1:0]  tune_o,
   input logic [PH_W-1:0]    phase_o,
   input logic               pdown_o,
   input logic               mult_en_o,
   input logic               serial_mode_o,
   input logic [FRAME_W-1:0] frame_q
);

   a_r4_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
      word_ptr_o <= PW'(NWORDS));

   a_r5_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_i && !$past(upd_i)) |=> (word_ptr_o == '0));

   a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      !(upd_i && !$past(upd_i)) |=>
         (word_ptr_o == $past(word_ptr_o)) || (word_ptr_o == $past(word_ptr_o) + 1'b1));

   a_r6_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
      !(upd_i && !$past(upd_i)) |=>
         ($stable(tune_o) && $stable(phase_o) && $stable(pdown_o) && $stable(mult_en_o)));

   a_r7_serial_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      serial_mode_o |=> serial_mode_o);

   a_r9_serial_ptr_idle: assert property (@(posedge clk) disable iff (!rst_n)
      serial_mode_o |-> (word_ptr_o == '0));

   a_r10_bad_serial: assert property (@(posedge clk) disable iff (!rst_n)
      (serial_mode_o && upd_i && !$past(upd_i) && frame_q[TUNE_W+1]) |=>
         ($stable(tune_o) && $stable(phase_o) && $stable(pdown_o) && $stable(mult_en_o)));

endmodule

bind dds_prog_loader dds_prog_loader_chk #(
   .NWORDS  (NWORDS),
   .PW      (PW),
   .TUNE_W  (TUNE_W),
   .PH_W    (PH_W),
   .FRAME_W (FRAME_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .upd_i         (upd_i),
   .word_ptr_o    (word_ptr_o),
   .tune_o        (tune_o),
   .phase_o       (phase_o),
   .pdown_o       (pdown_o),
   .mult_en_o     (mult_en_o),
   .serial_mode_o (serial_mode_o),
   .frame_q       (frame_q)
);

// File: tb/dds_prog_loader_test.sv
`timescale 1ns/1ps
module dds_prog_loader_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wclk_i = 1'b0;
   logic        upd_i = 1'b0;
   logic [7:0]  data_i = '0;
   logic        sdata_i = 1'b0;
   logic [31:0] tune_o;
   logic [4:0]  phase_o;
   logic        pdown_o;
   logic        mult_en_o;
   logic        serial_mode_o;
   logic [2:0]  word_ptr_o;

   int n_chk = 0;
   int n_fail = 0;
   bit ended = 0;

   // bench model, built from the requirements
   logic [39:0] m_frame = '0;
   int          m_ptr = 0;
   bit          m_ser = 0;
   logic [31:0] m_tune = '0;
   logic [4:0]  m_phase = '0;
   logic        m_pdn = 0;
   logic        m_mult = 0;

   localparam logic [39:0] VEC [5] = '{
      40'hF8_12345678,
      40'h05_DEADBEEF,
      40'h04_00000001,
      40'h01_FFFFFFFF,
      40'h50_80000000
   };

   dds_prog_loader uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .wclk_i        (wclk_i),
      .upd_i         (upd_i),
      .data_i        (data_i),
      .sdata_i       (sdata_i),
      .tune_o        (tune_o),
      .phase_o       (phase_o),
      .pdown_o       (pdown_o),
      .mult_en_o     (mult_en_o),
      .serial_mode_o (serial_mode_o),
      .word_ptr_o    (word_ptr_o)
   );

   always #4 clk = ~clk;

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      finish_run();
   end

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic chk_all(input string req);
      chk(req, "tune", 64'(tune_o), 64'(m_tune));
      chk(req, "phase", 64'(phase_o), 64'(m_phase));
      chk(req, "pdown", 64'(pdown_o), 64'(m_pdn));
      chk(req, "mult", 64'(mult_en_o), 64'(m_mult));
      chk(req, "serial", 64'(serial_mode_o), 64'(m_ser));
      chk(req, "ptr", 64'(word_ptr_o), 64'(m_ptr));
   endtask

   task automatic m_commit();
      if (!m_frame[33]) begin
         m_tune  = m_frame[31:0];
         m_phase = m_frame[39:35];
         m_pdn   = m_frame[34];
         m_mult  = m_frame[32];
      end else if (!m_ser && m_frame[34:32] == 3'b011) begin
         m_ser = 1;
      end
      m_ptr = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      m_ptr = 0; m_ser = 0; m_tune = '0; m_phase = '0; m_pdn = 0; m_mult = 0;
   endtask

   task automatic put_byte(input logic [7:0] b, input int hold);
      @(negedge clk);
      data_i = b;
      wclk_i = 1;
      repeat (hold) @(negedge clk);
      wclk_i = 0;
      if (!m_ser && m_ptr < 5) begin
         m_frame[39-8*m_ptr -: 8] = b;
         m_ptr++;
      end
   endtask

   task automatic put_word(input logic [39:0] w);
      for (int j = 0; j < 5; j++) put_byte(w[39-8*j -: 8], 1);
   endtask

   task automatic put_bits(input logic [39:0] w);
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         sdata_i = w[k];
         wclk_i = 1;
         @(negedge clk);
         wclk_i = 0;
         m_frame = {w[k], m_frame[39:1]};
      end
   endtask

   task automatic strobe();
      @(negedge clk);
      upd_i = 1;
      @(negedge clk);
      upd_i = 0;
      m_commit();
   endtask

   initial begin
      @(negedge clk);
      chk("R1", "serial in reset", 64'(serial_mode_o), 64'd0);
      chk("R1", "tune in reset", 64'(tune_o), 64'd0);
      rst_n = 1;
      @(negedge clk);
      chk_all("R1");

      // table walk: parallel loads (R2, R12, R5)
      for (int i = 0; i < 5; i++) begin
         put_word(VEC[i]);
         chk("R3", "ptr full", 64'(word_ptr_o), 64'd5);
         strobe();
         chk_all("R2");
         chk("R12", "pdown", 64'(pdown_o), 64'(VEC[i][34]));
         chk("R5", "ptr after update", 64'(word_ptr_o), 64'd0);
      end

      // R3: one long word-clock level counts once; R6: outputs hold
      put_byte(8'hA8, 4);
      chk("R3", "ptr after held edge", 64'(word_ptr_o), 64'd1);
      put_byte(8'h11, 1);
      put_byte(8'h22, 1);
      chk_all("R6");

      // R4: sixth byte dropped
      put_byte(8'h33, 1);
      put_byte(8'h44, 1);
      put_byte(8'h99, 1);
      chk("R4", "ptr saturated", 64'(word_ptr_o), 64'd5);
      strobe();
      chk_all("R4");
      chk("R4", "tune", 64'(tune_o), 64'h11223344);

      // R13: word clock and update together
      put_byte(8'h00, 1);
      put_byte(8'h55, 1);
      @(negedge clk);
      data_i = 8'h77; wclk_i = 1; upd_i = 1;
      @(negedge clk);
      wclk_i = 0; upd_i = 0;
      m_commit();
      chk_all("R13");
      chk("R13", "tune", 64'(tune_o), 64'h55223344);

      // R8: bit 33 with a non-entry code
      put_word(40'h07_01020304);
      strobe();
      chk_all("R8");
      chk("R8", "serial", 64'(serial_mode_o), 64'd0);

      // R11: frame survives reset
      put_word(40'h60_CAFEF00D);
      do_reset();
      chk_all("R1");
      strobe();
      chk_all("R11");
      chk("R11", "tune", 64'(tune_o), 64'hCAFEF00D);

      // R7: serial entry
      put_word(40'h03_00000000);
      strobe();
      chk_all("R7");
      chk("R7", "serial", 64'(serial_mode_o), 64'd1);
      chk("R7", "tune kept", 64'(tune_o), 64'hCAFEF00D);

      // R9: serial load, LSB first
      put_bits(40'h95_0F1E2D3C);
      chk("R9", "ptr idle", 64'(word_ptr_o), 64'd0);
      chk_all("R6");
      strobe();
      chk_all("R9");
      chk("R9", "tune", 64'(tune_o), 64'h0F1E2D3C);

      // R10: invalid serial word
      put_bits(40'h02_AAAAAAAA);
      strobe();
      chk_all("R10");
      chk("R10", "tune", 64'(tune_o), 64'h0F1E2D3C);

      // R11: reset leaves serial mode, keeps frame
      put_bits(40'hC1_13579BDF);
      do_reset();
      chk("R11", "serial cleared", 64'(serial_mode_o), 64'd0);
      strobe();
      chk_all("R11");
      chk("R11", "tune", 64'(tune_o), 64'h13579BDF);

      finish_run();
   end

endmodule